// File: doc/BRIEF.md
# Per-Line Colour Run Extractor

This block watches a raster stream of RGB pixels and classifies each pixel as matching when every colour channel lies inside a programmable window. On every line it finds each stretch of consecutive matching pixels and produces a run record that holds the line index and the first and last X position of the stretch. A line can produce any number of records, so logic downstream can see where a shape splits into branches.

Records wait in a small FIFO and leave through a valid/ready port. At each line end the block reports how many runs ended on that line. Across the frame it adds up the run lengths, and when the frame's last pixel arrives it presents the total as the tracked area. Pixels arrive one per cycle when `pix_valid` is high. `pix_sof` marks the first pixel of a frame, `pix_eol` marks the last pixel of each line and `pix_eof` marks the last pixel of the frame.

Top module: `color_run_extractor`

## Requirements
- R1: A pixel matches only when, for each channel, bound_lo <= value <= bound_hi (inclusive at both ends). The channel fields in `pix_rgb`, `bound_lo` and `bound_hi` are red in bits [23:16], green in [15:8] and blue in [7:0].
- R2: Every run record carries the line index, the X of the run's first matching pixel and the X of its last matching pixel, with left <= right. X counts accepted pixels from 0 at each line start. The line index is 0 on the `pix_sof` pixel and goes up by one after each `pix_eol` pixel.
- R3: When a line holds several separate runs, each produces its own record, and the records appear in left-to-right order.
- R4: If a run is still open on the `pix_eol` pixel, that run is closed with the line's last X as its right coordinate.
- R5: One cycle after a `pix_eol` pixel is accepted, `line_done` pulses for one cycle and `line_runs` gives the number of runs that ended on that line.
- R6: One cycle after a `pix_eof` pixel is accepted, `area_valid` pulses and `area` gives the sum of (right - left + 1) over every run of the frame. The sum restarts at `pix_sof`.
- R7: A record is removed only in a cycle where `rec_valid` and `rec_ready` are both high. While `rec_ready` is low, the presented record and `rec_valid` stay unchanged. The FIFO keeps records in order.
- R8: A record that arrives while the FIFO holds DEPTH records is discarded and sets `overflow`. `overflow` stays high until reset, and the records already queued are not affected.
- R9: Cycles with `pix_valid` low do not move X, do not open or close a run and do not change any output.
- R10: Right after reset, `rec_valid`, `line_done`, `area_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_eof | input | 1 | Last pixel of the frame |
| pix_rgb | input | 3*C_W | Pixel colour, R high, B low |
| bound_lo | input | 3*C_W | Lower colour limits per channel |
| bound_hi | input | 3*C_W | Upper colour limits per channel |
| rec_valid | output | 1 | Run record available |
| rec_ready | input | 1 | Consumer accepts record |
| rec_row | output | Y_W | Line index of record |
| rec_left | output | X_W | First X of the run |
| rec_right | output | X_W | Last X of the run |
| line_done | output | 1 | Line-end pulse |
| line_runs | output | X_W | Runs ended on the finished line |
| area_valid | output | 1 | Frame-end pulse |
| area | output | AREA_W | Summed run lengths of the frame |
| overflow | output | 1 | Sticky record-drop flag |

## Verification
The assertions check several properties on every cycle. A record that is held under back-pressure keeps its value. Every record has left <= right. The overflow flag never falls. The line and frame pulses appear only one cycle after an accepted line-end or frame-end pixel. The coordinates, the run counts and the area totals can only be judged against a model of the stimulus, so the bench scenarios show them. These scenarios cover runs that close at a line end, lines with several runs, idle gaps inside lines, pixels that sit exactly on the colour limits, and a FIFO that is driven full.

// File: rtl/crx_pkg.sv
package crx_pkg;
  typedef enum logic { RUN_IDLE = 1'b0, RUN_OPEN = 1'b1 } run_state_e;
endpackage

// File: rtl/crx_match.sv
module crx_match #(
  parameter int C_W = 8,
  parameter int NCH = 3
) (
  input  logic [NCH*C_W-1:0] pix,
  input  logic [NCH*C_W-1:0] lo,
  input  logic [NCH*C_W-1:0] hi,
  output logic               hit
);
  logic [NCH-1:0] ch_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_ok[c] = (pix[c*C_W +: C_W] >= lo[c*C_W +: C_W]) &&
                      (pix[c*C_W +: C_W] <= hi[c*C_W +: C_W]);
  end

  assign hit = &ch_ok;
endmodule

// File: rtl/crx_runner.sv
module crx_runner
  import crx_pkg::*;
#(
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int AREA_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic              pix_hit,
  input  logic              pix_sof,
  input  logic              pix_eol,
  input  logic              pix_eof,
  output logic              emit_valid,
  output logic [Y_W-1:0]    emit_row,
  output logic [X_W-1:0]    emit_left,
  output logic [X_W-1:0]    emit_right,
  output logic              line_done,
  output logic [X_W-1:0]    line_runs,
  output logic              area_valid,
  output logic [AREA_W-1:0] area
);
  run_state_e        st_q;
  logic [X_W-1:0]    x_q, start_q;
  logic [Y_W-1:0]    y_q;
  logic [AREA_W-1:0] acc_q;
  logic [X_W-1:0]    cnt_q;

  logic [X_W-1:0]    x_cur, c_left, c_right;
  logic [Y_W-1:0]    y_cur;
  logic              open_now, close_now;
  logic [X_W:0]      len;
  logic [AREA_W-1:0] acc_next;
  logic [X_W-1:0]    cnt_next;

  always_comb begin
    x_cur     = pix_sof ? '0 : x_q;
    y_cur     = pix_sof ? '0 : y_q;
    open_now  = (st_q == RUN_OPEN) && !pix_sof;
    close_now = 1'b0;
    c_left    = x_cur;
    c_right   = x_cur;
    if (pix_hit) begin
      if (pix_eol) begin
        close_now = 1'b1;
        c_left    = open_now ? start_q : x_cur;
      end
    end else if (open_now) begin
      close_now = 1'b1;
      c_left    = start_q;
      c_right   = x_cur - X_W'(1);
    end
    len      = {1'b0, c_right} - {1'b0, c_left} + (X_W+1)'(1);
    acc_next = (pix_sof ? '0 : acc_q) + (close_now ? AREA_W'(len) : '0);
    cnt_next = (pix_sof ? '0 : cnt_q) + X_W'(close_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RUN_IDLE;
      x_q        <= '0;
      y_q        <= '0;
      start_q    <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
      emit_valid <= 1'b0;
      emit_row   <= '0;
      emit_left  <= '0;
      emit_right <= '0;
      line_done  <= 1'b0;
      line_runs  <= '0;
      area_valid <= 1'b0;
      area       <= '0;
    end else begin
      emit_valid <= pix_valid && close_now;
      line_done  <= pix_valid && pix_eol;
      area_valid <= pix_valid && pix_eof;
      if (pix_valid) begin
        x_q   <= pix_eol ? '0 : x_cur + X_W'(1);
        y_q   <= pix_eol ? y_cur + Y_W'(1) : y_cur;
        st_q  <= (pix_hit && !pix_eol) ? RUN_OPEN : RUN_IDLE;
        if (pix_hit && !open_now) start_q <= x_cur;
        acc_q <= acc_next;
        cnt_q <= pix_eol ? '0 : cnt_next;
        if (close_now) begin
          emit_row   <= y_cur;
          emit_left  <= c_left;
          emit_right <= c_right;
        end
        if (pix_eol) line_runs <= cnt_next;
        if (pix_eof) area <= acc_next;
      end
    end
  end
endmodule

// File: rtl/crx_fifo.sv
module crx_fifo #(
  parameter int W     = 30,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         do_push, do_pop;

  assign not_empty = (wr_q != rd_q);
  assign full      = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign dout      = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + (AW+1)'(1);
      if (do_pop)  rd_q <= rd_q + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/color_run_extractor.sv
module color_run_extractor #(
  parameter int C_W    = 8,
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int AREA_W = 20,
  parameter int DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_valid,
  input  logic               pix_sof,
  input  logic               pix_eol,
  input  logic               pix_eof,
  input  logic [3*C_W-1:0]   pix_rgb,
  input  logic [3*C_W-1:0]   bound_lo,
  input  logic [3*C_W-1:0]   bound_hi,
  output logic               rec_valid,
  input  logic               rec_ready,
  output logic [Y_W-1:0]     rec_row,
  output logic [X_W-1:0]     rec_left,
  output logic [X_W-1:0]     rec_right,
  output logic               line_done,
  output logic [X_W-1:0]     line_runs,
  output logic               area_valid,
  output logic [AREA_W-1:0]  area,
  output logic               overflow
);
  localparam int REC_W = Y_W + 2*X_W;

  logic             hit, emit_valid, fifo_full;
  logic [Y_W-1:0]   emit_row;
  logic [X_W-1:0]   emit_left, emit_right;
  logic [REC_W-1:0] fifo_out;

  crx_match #(.C_W(C_W), .NCH(3)) u_match (
    .pix(pix_rgb), .lo(bound_lo), .hi(bound_hi), .hit(hit)
  );

  crx_runner #(.X_W(X_W), .Y_W(Y_W), .AREA_W(AREA_W)) u_runner (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_hit(hit),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .pix_eof(pix_eof),
    .emit_valid(emit_valid), .emit_row(emit_row), .emit_left(emit_left),
    .emit_right(emit_right), .line_done(line_done), .line_runs(line_runs),
    .area_valid(area_valid), .area(area)
  );

  crx_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(emit_valid),
    .din({emit_row, emit_left, emit_right}), .pop(rec_ready),
    .dout(fifo_out), .not_empty(rec_valid), .full(fifo_full)
  );

  assign {rec_row, rec_left, rec_right} = fifo_out;

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else if (emit_valid && fifo_full) overflow <= 1'b1;
  end
endmodule

// File: rtl/crx_checker.sv
module crx_checker #(
  parameter int X_W = 10,
  parameter int Y_W = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           pix_valid,
  input logic           pix_eol,
  input logic           pix_eof,
  input logic           rec_valid,
  input logic           rec_ready,
  input logic [Y_W-1:0] rec_row,
  input logic [X_W-1:0] rec_left,
  input logic [X_W-1:0] rec_right,
  input logic           line_done,
  input logic           area_valid,
  input logic           overflow
);
  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable({rec_row, rec_left, rec_right})));

  assert_left_not_past_right_R2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_left <= rec_right));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_line_pulse_follows_eol_R5: assert property (@(posedge clk) disable iff (rst)
    line_done |-> $past(pix_valid && pix_eol));

  assert_area_pulse_follows_eof_R6: assert property (@(posedge clk) disable iff (rst)
    area_valid |-> $past(pix_valid && pix_eof));
endmodule

bind color_run_extractor crx_checker #(.X_W(X_W), .Y_W(Y_W)) u_crx_checker (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_eol(pix_eol),
  .pix_eof(pix_eof), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_row(rec_row), .rec_left(rec_left), .rec_right(rec_right),
  .line_done(line_done), .area_valid(area_valid), .overflow(overflow)
);

// File: tb/tb_color_run_extractor.sv
module tb_color_run_extractor;
  localparam int C_W = 8, X_W = 10, Y_W = 10, AREA_W = 20, DEPTH = 4;
  localparam int LINE_W = 8;
  localparam logic [23:0] LO  = {8'd150, 8'd50, 8'd20};
  localparam logic [23:0] HI  = {8'd250, 8'd150, 8'd100};
  localparam logic [23:0] HIT = {8'd200, 8'd100, 8'd50};
  localparam logic [23:0] MISS = {8'd10, 8'd10, 8'd10};
  // {gap_mode, mask}; mask bit i is pixel x = i
  localparam logic [8:0] ROWTAB [6] = '{
    9'b0_0000_0000, 9'b0_0001_1100, 9'b0_1100_0011,
    9'b1_1010_0101, 9'b0_1111_1111, 9'b1_0100_0000 };

  logic clk = 0, rst = 1;
  logic pix_valid = 0, pix_sof = 0, pix_eol = 0, pix_eof = 0;
  logic [23:0] pix_rgb = '0;
  logic rec_ready = 1;
  logic rec_valid, line_done, area_valid, overflow;
  logic [Y_W-1:0] rec_row;
  logic [X_W-1:0] rec_left, rec_right, line_runs;
  logic [AREA_W-1:0] area;

  int checks = 0, errors = 0;
  bit rec_mon_en = 1;
  logic [29:0] recq[$];
  int lineq[$];
  int areaq[$];
  int area_acc;

  always #10 clk = ~clk;

  color_run_extractor #(.C_W(C_W), .X_W(X_W), .Y_W(Y_W), .AREA_W(AREA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .pix_eof(pix_eof), .pix_rgb(pix_rgb), .bound_lo(LO), .bound_hi(HI),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_row(rec_row), .rec_left(rec_left),
    .rec_right(rec_right), .line_done(line_done), .line_runs(line_runs),
    .area_valid(area_valid), .area(area), .overflow(overflow));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitors sample away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rec_mon_en && rec_valid && rec_ready) begin
        if (recq.size() == 0) check(0, "R2 unexpected record", {rec_row, rec_left, rec_right}, 0);
        else begin
          logic [29:0] e;
          e = recq.pop_front();
          check({rec_row, rec_left, rec_right} == e, "R2/R3/R4 run record",
                {rec_row, rec_left, rec_right}, e);
        end
      end
      if (line_done) begin
        if (lineq.size() == 0) check(0, "R5 unexpected line_done", line_runs, 0);
        else begin
          int e;
          e = lineq.pop_front();
          check(line_runs == X_W'(e), "R5 line run count", line_runs, e);
        end
      end
      if (area_valid) begin
        if (areaq.size() == 0) check(0, "R6 unexpected area", area, 0);
        else begin
          int e;
          e = areaq.pop_front();
          check(area == AREA_W'(e), "R6 frame area", area, e);
        end
      end
    end
  end

  task automatic drive_pix(input logic [23:0] c, input bit s, input bit l, input bit f);
    @(negedge clk);
    pix_valid = 1; pix_rgb = c; pix_sof = s; pix_eol = l; pix_eof = f;
  endtask

  task automatic idle();
    @(negedge clk);
    pix_valid = 0; pix_rgb = HIT; pix_sof = 1; pix_eol = 1; pix_eof = 1; // junk, ignored (R9)
  endtask

  // Independent model: expected runs of one line from its mask
  task automatic expect_row(input logic [7:0] m, input int row, input bit push_recs);
    int n = 0, st = -1;
    for (int x = 0; x <= LINE_W; x++) begin
      bit h = (x < LINE_W) ? m[x] : 1'b0;
      if (h && st < 0) st = x;
      if (!h && st >= 0) begin
        if (push_recs) recq.push_back({Y_W'(row), X_W'(st), X_W'(x - 1)});
        area_acc += x - st;
        n++;
        st = -1;
      end
    end
    lineq.push_back(n);
  endtask

  task automatic send_row(input logic [7:0] m, input int row, input bit first,
                          input bit last, input bit gaps);
    for (int x = 0; x < LINE_W; x++) begin
      drive_pix(m[x] ? HIT : MISS, first && x == 0, x == LINE_W - 1, last && x == LINE_W - 1);
      if (gaps && (x % 2 == 0)) idle();
    end
  endtask

  task automatic drain(input string req);
    repeat (6) @(negedge clk);
    check(recq.size() == 0, req, recq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check(rec_valid == 0, "R10 rec_valid", rec_valid, 0);
    check(line_done == 0, "R10 line_done", line_done, 0);
    check(area_valid == 0, "R10 area_valid", area_valid, 0);
    check(overflow == 0, "R10 overflow", overflow, 0);

    // Table-driven frame: R2 R3 R4 R9 (gap rows) R5 R6
    area_acc = 0;
    for (int r = 0; r < 6; r++) begin
      expect_row(ROWTAB[r][7:0], r, 1);
      send_row(ROWTAB[r][7:0], r, r == 0, r == 5, ROWTAB[r][8]);
    end
    areaq.push_back(area_acc);
    idle(); pix_sof = 0; pix_eol = 0; pix_eof = 0;
    drain("R3 all frame-1 records seen");
    check(area_acc == 20, "R6 model sanity", area_acc, 20);

    // Single-pixel frame: row restarts at 0, area restarts (R2, R6)
    area_acc = 0;
    recq.push_back({Y_W'(0), X_W'(0), X_W'(0)});
    lineq.push_back(1);
    areaq.push_back(1);
    drive_pix(HIT, 1, 1, 1);
    idle();
    drain("R2 single pixel frame record");

    // Bound edges R1: lo, hi, R lo-1, hit, G hi+1, hit, hit, B lo-1
    recq.push_back({Y_W'(0), X_W'(0), X_W'(1)});
    recq.push_back({Y_W'(0), X_W'(3), X_W'(3)});
    recq.push_back({Y_W'(0), X_W'(5), X_W'(6)});
    lineq.push_back(3);
    areaq.push_back(5);
    drive_pix(LO, 1, 0, 0);
    drive_pix(HI, 0, 0, 0);
    drive_pix({8'd149, 8'd100, 8'd50}, 0, 0, 0);
    drive_pix(HIT, 0, 0, 0);
    drive_pix({8'd200, 8'd151, 8'd50}, 0, 0, 0);
    drive_pix(HIT, 0, 0, 0);
    drive_pix(HIT, 0, 0, 0);
    drive_pix({8'd200, 8'd100, 8'd19}, 0, 1, 1);
    idle();
    drain("R1 inclusive colour bounds");

    // Backpressure and overflow R7 R8
    rec_mon_en = 0;
    @(negedge clk); rec_ready = 0;
    area_acc = 0;
    expect_row(8'b1010_1010, 0, 0);
    expect_row(8'b0000_0001, 1, 0);
    areaq.push_back(area_acc);
    send_row(8'b1010_1010, 0, 1, 0, 0);
    send_row(8'b0000_0001, 1, 0, 1, 0);
    idle();
    repeat (4) @(negedge clk);
    check(overflow == 1, "R8 overflow set on drop", overflow, 1);
    check(rec_valid == 1, "R7 record held while not ready", rec_valid, 1);
    begin
      logic [29:0] held;
      held = {rec_row, rec_left, rec_right};
      repeat (3) @(negedge clk);
      check({rec_row, rec_left, rec_right} == held, "R7 stalled record stable",
            {rec_row, rec_left, rec_right}, held);
    end
    for (int k = 0; k < 4; k++) begin
      logic [29:0] e;
      e = {Y_W'(0), X_W'(2*k + 1), X_W'(2*k + 1)};
      check(rec_valid == 1, "R7 queued record present", rec_valid, 1);
      check({rec_row, rec_left, rec_right} == e, "R7/R8 queued order",
            {rec_row, rec_left, rec_right}, e);
      rec_ready = 1;
      @(negedge clk);
      rec_ready = 0;
    end
    check(rec_valid == 0, "R8 fifth record dropped", rec_valid, 0);
    repeat (3) @(negedge clk);
    check(overflow == 1, "R8 overflow stays high", overflow, 1);
    check(lineq.size() == 0 && areaq.size() == 0, "R5/R6 line and area with overflow",
          lineq.size() + areaq.size(), 0);

    finish_run();
  end
endmodule